// File: doc/BRIEF.md
# Frame-Committing Flow-Control Receive Buffer

This block buffers the 32-bit control words of frames arriving from a switch fabric and hands them to a processor that polls for them. Words arrive on a write port that carries start-of-frame, end-of-frame and error markers. A frame is held back while it is being written. It becomes visible to the reader only when its last word arrives with no error in the frame and with room for every word. A frame with an error, or one that does not fit, is rolled back as a whole, and committed words are never overwritten.

The reader asks for a burst of 1 to 16 words and receives one word per cycle. Beats for which no committed word exists return a fixed idle word. Three status outputs are provided. `not_empty` says committed words are waiting. `above_limit` says the committed occupancy exceeds a programmable upper limit. `fc_pause` asks the upstream sender to pause while that condition holds.

Top module: `fcrx_buffer`

## Requirements
- R1: A synchronous active-high reset empties the buffer, loads the upper limit with `LIMIT_RST`, and drives `not_empty`, `above_limit`, `fc_pause` and `rd_valid` low.
- R2: Words of a frame that has not yet ended never count as committed. `not_empty` stays low while only a partial frame is present, and reads return the idle word.
- R3: An end-of-frame word accepted with no error in its frame commits the frame. `not_empty` is high in the cycle after that word's clock edge, and reads return the frame's words in arrival order.
- R4: A frame with `wr_err` high on any of its words, including the last, is discarded at its end and leaves committed contents and status unchanged.
- R5: A frame whose words do not all fit in the `DEPTH` entries is discarded at its end, and the committed words already present are read back intact.
- R6: A request accepted on `rd_req` with `rd_len_m1` = L gives exactly L+1 consecutive cycles of `rd_valid`, starting one cycle after the accepting edge. `rd_req` is ignored while `rd_busy` is high.
- R7: A read beat with no committed word returns 0x0000FFFF. A burst longer than the committed count returns the committed words first and then the idle word.
- R8: `not_empty` stays high until every committed word has been read, including words from frames committed while earlier words were still waiting.
- R9: `above_limit` is high exactly when the committed word count is strictly greater than the limit. `cfg_we` loads the limit from `cfg_limit`.
- R10: `fc_pause` is asserted whenever `above_limit` is high and deasserted whenever it is low.
- R11: A word that arrives with no frame open and without start-of-frame is ignored. A start-of-frame inside an open frame drops the open frame's words and begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word present |
| wr_data | input | 32 | Write word |
| wr_sof | input | 1 | Word opens a frame |
| wr_eof | input | 1 | Word closes a frame |
| wr_err | input | 1 | Word is marked errored |
| rd_req | input | 1 | Burst read request |
| rd_len_m1 | input | 4 | Burst length minus one |
| rd_valid | output | 1 | Read beat present |
| rd_data | output | 32 | Read word or idle word |
| rd_busy | output | 1 | Burst in progress |
| cfg_we | input | 1 | Load upper limit |
| cfg_limit | input | $clog2(DEPTH)+1 | New upper limit |
| not_empty | output | 1 | Committed words waiting |
| above_limit | output | 1 | Committed count above limit |
| fc_pause | output | 1 | Pause request to sender |

## Verification
The bench builds the buffer with `DEPTH` = 16 and `LIMIT_RST` = 12. A shallow store makes the overflow rollback reachable with short frames: 13 committed words followed by a 4-word frame do not fit, and a 17-word frame cannot fit even into an empty buffer. A frame of exactly 16 words fills the store with no room to spare. With a reset limit of 12, the strict comparison is tested at both 12 and 13 committed words before a limit is written through the register port. Bursts of the full 16 beats then cover the case where committed words run out partway through and the idle word fills the remaining beats.

// File: rtl/fcrx_pkg.sv
package fcrx_pkg;

    localparam int WORD_W    = 32;
    localparam int BURST_MAX = 16;
    localparam int LEN_W     = $clog2(BURST_MAX);

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t IDLE_WORD = 32'h0000_FFFF;

    typedef struct packed {
        logic  valid;
        logic  sof;
        logic  eof;
        logic  err;
        word_t data;
    } wr_beat_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } rd_beat_t;

    // Value to return on a read beat: stored word if one is committed
    function automatic word_t beat_word(input logic have, input word_t stored);
        return have ? stored : IDLE_WORD;
    endfunction

endpackage

// File: rtl/fcrx_store.sv
module fcrx_store
    import fcrx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);

    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/fcrx_wr_ctrl.sv
module fcrx_wr_ctrl
    import fcrx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_beat_t      beat,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output word_t         mem_wdata,
    output logic [PW-1:0] wp_commit,
    output logic [PW-1:0] wp_spec,
    output logic          commit_fire
);

    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] ONE_P   = PW'(1);

    logic          in_frame;
    logic          frame_bad;
    logic [PW-1:0] base;
    logic [PW-1:0] used;
    logic [PW-1:0] nxt;
    logic          room;
    logic          active;
    logic          bad_now;

    always_comb begin
        base    = beat.sof ? wp_commit : wp_spec;
        used    = base - rd_ptr;
        room    = used < DEPTH_P;
        active  = beat.valid && (in_frame || beat.sof);
        bad_now = (!beat.sof && frame_bad) || beat.err || !room;
        nxt     = room ? base + ONE_P : base;
    end

    assign mem_we      = active && room;
    assign mem_waddr   = base[AW-1:0];
    assign mem_wdata   = beat.data;
    assign commit_fire = active && beat.eof && !bad_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame  <= 1'b0;
            frame_bad <= 1'b0;
            wp_commit <= '0;
            wp_spec   <= '0;
        end else if (active) begin
            if (beat.eof) begin
                in_frame  <= 1'b0;
                frame_bad <= 1'b0;
                if (bad_now) begin
                    wp_spec <= wp_commit;
                end else begin
                    wp_commit <= nxt;
                    wp_spec   <= nxt;
                end
            end else begin
                in_frame  <= 1'b1;
                frame_bad <= bad_now;
                wp_spec   <= nxt;
            end
        end
    end

    // R5: speculative region never reaches past the free space
    p_spec_within_depth_r5: assert property (@(posedge clk) disable iff (rst)
        (wp_spec - rd_ptr) <= DEPTH_P);

    // R4: a discarded frame leaves the committed pointer where it was
    p_reject_keeps_commit_r4: assert property (@(posedge clk) disable iff (rst)
        (active && beat.eof && bad_now) |=> (wp_commit == $past(wp_commit) && wp_spec == wp_commit));

endmodule

// File: rtl/fcrx_rd_ctrl.sv
module fcrx_rd_ctrl
    import fcrx_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [LEN_W-1:0] len_m1,
    input  logic [PW-1:0]    commit_cnt,
    input  word_t            mem_rdata,
    output logic [PW-1:0]    rd_ptr,
    output rd_beat_t         out,
    output logic             busy
);

    localparam logic [LEN_W:0] ONE_L = (LEN_W+1)'(1);
    localparam logic [PW-1:0]  ONE_P = PW'(1);

    logic [LEN_W:0] beats_left;
    logic           beat_go;
    logic           have;

    assign beat_go = beats_left != '0;
    assign have    = commit_cnt != '0;
    assign busy    = beat_go;

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_left <= '0;
            rd_ptr     <= '0;
            out        <= '0;
        end else begin
            out.valid <= beat_go;
            if (beat_go) begin
                out.data   <= beat_word(have, mem_rdata);
                beats_left <= beats_left - ONE_L;
                if (have) begin
                    rd_ptr <= rd_ptr + ONE_P;
                end
            end else if (req) begin
                beats_left <= {1'b0, len_m1} + ONE_L;
            end
        end
    end

    // R7: a beat issued with nothing committed yields the idle word
    p_idle_on_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (beat_go && !have) |=> (out.valid && out.data == IDLE_WORD));

    // R3: the read pointer moves only over committed words
    p_ptr_needs_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_ptr != $past(rd_ptr)) |-> ($past(commit_cnt) != '0));

    // R6: a new request is not taken while a burst runs
    p_busy_blocks_req_r6: assert property (@(posedge clk) disable iff (rst)
        (beat_go && req) |=> (beats_left == $past(beats_left) - ONE_L));

endmodule

// File: rtl/fcrx_buffer.sv
module fcrx_buffer
    import fcrx_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int LIMIT_RST = 24,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [31:0]      wr_data,
    input  logic             wr_sof,
    input  logic             wr_eof,
    input  logic             wr_err,
    input  logic             rd_req,
    input  logic [LEN_W-1:0] rd_len_m1,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             rd_busy,
    input  logic             cfg_we,
    input  logic [PW-1:0]    cfg_limit,
    output logic             not_empty,
    output logic             above_limit,
    output logic             fc_pause
);

    wr_beat_t      wbeat;
    rd_beat_t      rbeat;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    word_t         mem_wdata;
    word_t         mem_rdata;
    logic [PW-1:0] wp_commit;
    logic [PW-1:0] wp_spec;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] commit_cnt;
    logic [PW-1:0] limit_q;
    logic          commit_fire;

    assign wbeat = '{valid: wr_valid, sof: wr_sof, eof: wr_eof, err: wr_err, data: wr_data};

    fcrx_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .beat        (wbeat),
        .rd_ptr      (rd_ptr),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .wp_commit   (wp_commit),
        .wp_spec     (wp_spec),
        .commit_fire (commit_fire)
    );

    fcrx_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_ptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    assign commit_cnt = wp_commit - rd_ptr;

    fcrx_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .req        (rd_req),
        .len_m1     (rd_len_m1),
        .commit_cnt (commit_cnt),
        .mem_rdata  (mem_rdata),
        .rd_ptr     (rd_ptr),
        .out        (rbeat),
        .busy       (rd_busy)
    );

    assign rd_valid = rbeat.valid;
    assign rd_data  = rbeat.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            limit_q <= PW'(LIMIT_RST);
        end else if (cfg_we) begin
            limit_q <= cfg_limit;
        end
    end

    assign not_empty   = commit_cnt != '0;
    assign above_limit = commit_cnt > limit_q;
    assign fc_pause    = above_limit;

    // R2: not_empty can only rise right after a clean commit
    p_rise_after_commit_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(not_empty) |-> $past(commit_fire));

    // R5: committed words never exceed the store
    p_commit_bound_r5: assert property (@(posedge clk) disable iff (rst)
        commit_cnt <= PW'(DEPTH));

    // R8: with no read beat, not_empty cannot drop
    p_hold_without_read_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(not_empty) && !$past(rd_busy)) |-> not_empty);

endmodule

// File: tb/tb_fcrx_buffer.sv
module tb_fcrx_buffer;
    import fcrx_pkg::*;

    localparam int DEPTH     = 16;
    localparam int LIMIT_RST = 12;
    localparam int PW        = $clog2(DEPTH) + 1;

    // vector: {frame length[4:0], error on last word, read length[4:0]}
    localparam int NV = 7;
    localparam logic [10:0] VECS [NV] = '{
        {5'd3,  1'b0, 5'd3},
        {5'd4,  1'b1, 5'd2},
        {5'd1,  1'b0, 5'd4},
        {5'd16, 1'b0, 5'd16},
        {5'd5,  1'b0, 5'd2},
        {5'd6,  1'b0, 5'd9},
        {5'd17, 1'b0, 5'd1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_valid = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             wr_sof = 1'b0;
    logic             wr_eof = 1'b0;
    logic             wr_err = 1'b0;
    logic             rd_req = 1'b0;
    logic [LEN_W-1:0] rd_len_m1 = '0;
    logic             rd_valid;
    logic [31:0]      rd_data;
    logic             rd_busy;
    logic             cfg_we = 1'b0;
    logic [PW-1:0]    cfg_limit = '0;
    logic             not_empty;
    logic             above_limit;
    logic             fc_pause;

    int    n_chk = 0;
    int    n_bad = 0;
    int    limit_v = LIMIT_RST;
    word_t model [$];

    always #2.5 clk = ~clk;

    fcrx_buffer #(.DEPTH(DEPTH), .LIMIT_RST(LIMIT_RST)) dut (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_err(wr_err),
        .rd_req(rd_req), .rd_len_m1(rd_len_m1), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_busy(rd_busy), .cfg_we(cfg_we),
        .cfg_limit(cfg_limit), .not_empty(not_empty),
        .above_limit(above_limit), .fc_pause(fc_pause)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic status_chk(input string req);
        chk(not_empty == (model.size() != 0), {req, " not_empty"}, 32'(not_empty), 32'(model.size() != 0));
        chk(above_limit == (model.size() > limit_v), "R9 above_limit", 32'(above_limit), 32'(model.size() > limit_v));
        chk(fc_pause == (model.size() > limit_v), "R10 fc_pause", 32'(fc_pause), 32'(model.size() > limit_v));
    endtask

    task automatic put_word(input logic [31:0] d, input bit sof, input bit eof, input bit err);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_sof = sof; wr_eof = eof; wr_err = err;
        @(negedge clk);
        wr_valid = 1'b0; wr_sof = 1'b0; wr_eof = 1'b0; wr_err = 1'b0;
    endtask

    // bad_at < 0: clean frame
    task automatic send_frame(input int n, input int bad_at, input logic [31:0] base);
        for (int w = 0; w < n; w++) begin
            put_word(base + 32'(w), w == 0, w == n - 1, w == bad_at);
        end
        if (bad_at < 0 && model.size() + n <= DEPTH) begin
            for (int w = 0; w < n; w++) model.push_back(base + 32'(w));
        end
    endtask

    task automatic read_burst(input int n);
        word_t e;
        @(negedge clk);
        rd_req = 1'b1; rd_len_m1 = LEN_W'(n - 1);
        @(negedge clk);
        rd_req = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            e = (model.size() != 0) ? model.pop_front() : IDLE_WORD;
            chk(rd_valid == 1'b1, "R6 beat valid", 32'(rd_valid), 32'd1);
            chk(rd_data == e, (e == IDLE_WORD) ? "R7 data" : "R3 data", rd_data, e);
        end
        @(negedge clk);
        chk(rd_valid == 1'b0, "R6 burst end", 32'(rd_valid), 32'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model.delete();
        limit_v = LIMIT_RST;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk(!not_empty && !above_limit && !fc_pause && !rd_valid, "R1 reset outputs",
            {28'd0, not_empty, above_limit, fc_pause, rd_valid}, 32'd0);

        // R11 stray words outside a frame
        put_word(32'h1111_0000, 1'b0, 1'b0, 1'b0);
        put_word(32'h1111_0001, 1'b0, 1'b1, 1'b0);
        status_chk("R11");

        // R2 partial frame invisible, R7 idle read
        put_word(32'h2222_0000, 1'b1, 1'b0, 1'b0);
        put_word(32'h2222_0001, 1'b0, 1'b0, 1'b0);
        status_chk("R2");
        read_burst(1);
        put_word(32'h2222_0002, 1'b0, 1'b1, 1'b0);
        for (int w = 0; w < 3; w++) model.push_back(32'h2222_0000 + 32'(w));
        status_chk("R3");
        read_burst(3);
        status_chk("R8");

        // R11 restart on a second start-of-frame
        put_word(32'h3333_00A0, 1'b1, 1'b0, 1'b0);
        put_word(32'h3333_00A1, 1'b0, 1'b0, 1'b0);
        send_frame(2, -1, 32'h3333_00B0);
        status_chk("R11");
        read_burst(2);

        // R4 error on a middle word
        send_frame(3, 1, 32'h4444_0000);
        status_chk("R4");

        // R8 not_empty held across later commits
        send_frame(2, -1, 32'h5555_0000);
        read_burst(1);
        send_frame(1, -1, 32'h5555_0010);
        status_chk("R8");
        read_burst(1);
        status_chk("R8");
        read_burst(1);
        status_chk("R8");

        // R6 request while busy is ignored
        send_frame(3, -1, 32'h6666_0000);
        @(negedge clk);
        rd_req = 1'b1; rd_len_m1 = 4'd1;
        @(negedge clk);
        rd_req = 1'b1; rd_len_m1 = 4'd3;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid && rd_data == 32'h6666_0000, "R6 busy beat1", rd_data, 32'h6666_0000);
        @(negedge clk);
        chk(rd_valid && rd_data == 32'h6666_0001, "R6 busy beat2", rd_data, 32'h6666_0001);
        @(negedge clk);
        chk(!rd_valid, "R6 ignored request", 32'(rd_valid), 32'd0);
        void'(model.pop_front()); void'(model.pop_front());
        status_chk("R6");
        read_burst(1);

        // R9/R10 reset limit, strict compare; R5 overflow rollback
        send_frame(12, -1, 32'h7777_0000);
        status_chk("R9");
        send_frame(1, -1, 32'h7777_0100);
        status_chk("R10");
        send_frame(4, -1, 32'h7777_0200);
        status_chk("R5");
        read_burst(16);
        status_chk("R5");

        // R9 programmed limit
        @(negedge clk);
        cfg_we = 1'b1; cfg_limit = PW'(2);
        @(negedge clk);
        cfg_we = 1'b0;
        limit_v = 2;
        send_frame(3, -1, 32'h8888_0000);
        status_chk("R9");
        read_burst(1);
        status_chk("R9");
        read_burst(2);

        // R1 reset mid-operation restores limit and clears contents
        send_frame(5, -1, 32'h9999_0000);
        do_reset();
        status_chk("R1");
        read_burst(1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            send_frame(int'(VECS[v][10:6]), VECS[v][5] ? int'(VECS[v][10:6]) - 1 : -1,
                       32'hA000_0000 + 32'(v) * 32'h100);
            status_chk(VECS[v][5] ? "R4" : "R3");
            read_burst(int'(VECS[v][4:0]));
            status_chk("R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule